// File: doc/BRIEF.md
# Request Steering Tag Selector

This block sits between a device's request generator and its packet builder. Each memory request the device starts is decorated with a processing hint and, when enabled, an 8-bit steering tag. The platform uses the tag to pick a target resource, such as a particular cache. The hint depends on the kind of data the request touches: control descriptors, packet headers or bulk payload. Software sets one 2-bit hint value per class.

The tag source comes from a level-sensitive mode input, which is sampled when a request is accepted. Three sources are supported:
- **No tag:** no tag is emitted and steering is left to the platform.
- **Interrupt vector:** the tag is looked up using the request's interrupt vector index.
- **Device context:** the tag is looked up using a device context index that is independent of interrupt routing.

A 64-entry table, loaded through a synchronous write port, supplies tags in both lookup modes. Every entry has a valid bit. A lookup that hits a cleared entry behaves as if no tag were in use.

The block adds one register stage with valid/ready handshaking on both sides. Request fields pass through unchanged.

Top module: `hint_tagger`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every table entry is unprogrammed.
- R2: A request accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after exactly that edge. While `out_valid` is high and `out_ready` is low, all outputs hold and `in_ready` is low.
- R3: Only request kinds 2'b01 (memory read), 2'b10 (memory write) and 2'b11 (atomic) may carry a hint. Kind 2'b00 (any other request) always leaves with `out_hint_en`=0, `out_hint`=0 and `out_tag`=0.
- R4: For a hintable kind, class 0 (descriptor), 1 (header) and 2 (payload) give `out_hint_en`=1 with that class's hint value. Class 3 (unclassified) gives `out_hint_en`=0, hint 0 and tag 0.
- R5: After reset the per-class hints are: descriptor 2'b00 (bidirectional), header 2'b01 (requester), payload 2'b10 (target). A hint write (`hint_we`, `hint_cls`, `hint_val`) replaces the value for that class in later requests.
- R6: Mode 2'b00 (no tag) and mode 2'b11 (treated the same way) give `out_tag`=0 while still attaching the class hint.
- R7: Mode 2'b01 (vector) gives `out_tag` equal to the tag stored at table index `in_vec`.
- R8: Mode 2'b10 (context) gives `out_tag` equal to the tag stored at table index `in_ctx`, whatever `in_vec` holds.
- R9: If the selected table entry's valid bit is clear, `out_tag` is 0 and the hint is still attached. A table write with `tbl_wvld`=0 unprograms that entry.
- R10: The mode applies only to requests accepted while it is present. A request already held at the output keeps its tag when the mode changes.
- R11: `out_kind`, `out_class` and `out_addr` equal the accepted `in_kind`, `in_class` and `in_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Tag source: 0 none, 1 vector, 2 context, 3 none |
| tbl_we | input | 1 | Table write enable |
| tbl_widx | input | 6 | Table entry to write |
| tbl_wtag | input | 8 | Tag value to store |
| tbl_wvld | input | 1 | Valid bit to store |
| hint_we | input | 1 | Per-class hint write enable |
| hint_cls | input | 2 | Class whose hint is written (0..2) |
| hint_val | input | 2 | New hint value |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with `in_valid` |
| in_kind | input | 2 | Request kind, encoded as in R3 |
| in_class | input | 2 | Data-structure class, encoded as in R4 |
| in_vec | input | 6 | Interrupt vector index |
| in_ctx | input | 6 | Device context index |
| in_addr | input | 32 | Request address |
| out_valid | output | 1 | Decorated request present |
| out_ready | input | 1 | Downstream accepts |
| out_kind | output | 2 | Passed-through kind |
| out_class | output | 2 | Passed-through class |
| out_addr | output | 32 | Passed-through address |
| out_hint_en | output | 1 | Hint present |
| out_hint | output | 2 | Hint value |
| out_tag | output | 8 | Steering tag, 0 when none |

## Verification
Table and hint writes take effect on the clock edge that samples them, so a request accepted on the following edge already sees the new values. Every decorated result is due one edge after its acceptance edge. The bench drives inputs on falling edges and reads the outputs on the falling edge right after the acceptance edge. For the backpressure and mode-change cases, the outputs are read again on later falling edges while `out_ready` is low, to confirm that the held values have not moved.

// File: rtl/hint_tagger.sv
module hint_tagger #(
  parameter int DEPTH  = 64,
  parameter int TAG_W  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_widx,
  input  logic [TAG_W-1:0]  tbl_wtag,
  input  logic              tbl_wvld,
  input  logic              hint_we,
  input  logic [1:0]        hint_cls,
  input  logic [1:0]        hint_val,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [1:0]        in_class,
  input  logic [IDX_W-1:0]  in_vec,
  input  logic [IDX_W-1:0]  in_ctx,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [1:0]        out_class,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_hint_en,
  output logic [1:0]        out_hint,
  output logic [TAG_W-1:0]  out_tag
);
  localparam logic [1:0] MODE_VEC = 2'b01;
  localparam logic [1:0] MODE_CTX = 2'b10;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] tag_ok;
  logic [1:0]       cls_hint [3];

  logic             take, use_tbl, hintable, ent_ok;
  logic [IDX_W-1:0] sel_idx;
  logic [1:0]       hint_nx;
  logic [TAG_W-1:0] tag_nx;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign use_tbl  = (mode_sel == MODE_VEC) || (mode_sel == MODE_CTX);
  assign sel_idx  = (mode_sel == MODE_VEC) ? in_vec : in_ctx;
  assign hintable = (in_kind != 2'b00) && (in_class != 2'b11);
  assign ent_ok   = use_tbl && tag_ok[sel_idx];
  assign hint_nx  = hintable ? cls_hint[in_class] : 2'b00;
  assign tag_nx   = (hintable && ent_ok) ? tag_mem[sel_idx] : '0;

  always_ff @(posedge clk) begin
    if (tbl_we) tag_mem[tbl_widx] <= tbl_wtag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_ok      <= '0;
      cls_hint[0] <= 2'b00;
      cls_hint[1] <= 2'b01;
      cls_hint[2] <= 2'b10;
    end else begin
      if (tbl_we) tag_ok[tbl_widx] <= tbl_wvld;
      if (hint_we && hint_cls != 2'b11) cls_hint[hint_cls] <= hint_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_kind    <= '0;
      out_class   <= '0;
      out_addr    <= '0;
      out_hint_en <= 1'b0;
      out_hint    <= '0;
      out_tag     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_kind    <= in_kind;
        out_class   <= in_class;
        out_addr    <= in_addr;
        out_hint_en <= hintable;
        out_hint    <= hint_nx;
        out_tag     <= tag_nx;
      end
    end
  end
endmodule

module hint_tagger_chk #(
  parameter int TAG_W  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_kind,
  input logic [1:0]        in_class,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_hint_en,
  input logic [1:0]        out_hint,
  input logic [TAG_W-1:0]  out_tag
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_accept_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_tag) && $stable(out_hint)
      && $stable(out_addr) && $stable(out_kind));

  assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_other_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'b00) |-> (!out_hint_en && out_tag == '0 && out_hint == 2'b00));

  assert_unclassed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_class == 2'b11) |=> !out_hint_en);

  assert_notag_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (mode_sel == 2'b00 || mode_sel == 2'b11)) |=> out_tag == '0);
endmodule

bind hint_tagger hint_tagger_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
  .in_ready(in_ready), .in_kind(in_kind), .in_class(in_class),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_addr(out_addr), .out_hint_en(out_hint_en), .out_hint(out_hint),
  .out_tag(out_tag)
);

// File: tb/sim_hint_tagger.sv
`timescale 1ns/1ps
module sim_hint_tagger;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode_sel = 0;
  logic tbl_we = 0, tbl_wvld = 0, hint_we = 0;
  logic [5:0] tbl_widx = 0;
  logic [7:0] tbl_wtag = 0;
  logic [1:0] hint_cls = 0, hint_val = 0;
  logic in_valid = 0, out_ready = 1;
  logic in_ready;
  logic [1:0] in_kind = 0, in_class = 0;
  logic [5:0] in_vec = 0, in_ctx = 0;
  logic [31:0] in_addr = 0;
  logic out_valid, out_hint_en;
  logic [1:0] out_kind, out_class, out_hint;
  logic [31:0] out_addr;
  logic [7:0] out_tag;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hint_tagger u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input int tag, input bit vld);
    @(negedge clk);
    tbl_we = 1; tbl_widx = 6'(idx); tbl_wtag = 8'(tag); tbl_wvld = vld;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic sethint(input int cls, input int val);
    @(negedge clk);
    hint_we = 1; hint_cls = 2'(cls); hint_val = 2'(val);
    @(negedge clk);
    hint_we = 0;
  endtask

  task automatic send(input int kind, input int cls, input int vec, input int ctx,
                      input int addr);
    @(negedge clk);
    out_ready = 1;
    in_valid = 1; in_kind = 2'(kind); in_class = 2'(cls);
    in_vec = 6'(vec); in_ctx = 6'(ctx); in_addr = 32'(addr);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    mode_sel = 2'b01;
    send(1, 0, 5, 0, 0);
    chk(out_tag == 0, "R1 empty table", out_tag, 0);
  endtask

  task automatic t_defaults;
    mode_sel = 2'b00;
    send(1, 0, 0, 0, 32'h100);
    chk(out_valid && out_hint_en && out_hint == 2'b00, "R5 desc hint", out_hint, 0);
    send(2, 1, 0, 0, 32'h104);
    chk(out_hint_en && out_hint == 2'b01, "R5 header hint", out_hint, 1);
    send(3, 2, 0, 0, 32'h108);
    chk(out_hint_en && out_hint == 2'b10, "R5 payload hint", out_hint, 2);
    chk(out_addr == 32'h108 && out_kind == 2'b11 && out_class == 2'b10, "R11 passthru",
        out_addr, 32'h108);
    chk(out_tag == 0, "R6 none mode tag", out_tag, 0);
  endtask

  task automatic t_other;
    mode_sel = 2'b01;
    load(3, 8'h5a, 1);
    send(0, 0, 3, 0, 32'h200);
    chk(!out_hint_en && out_hint == 0 && out_tag == 0, "R3 other kind", out_tag, 0);
    send(1, 3, 3, 0, 32'h204);
    chk(!out_hint_en && out_tag == 0, "R4 unclassified", out_hint_en, 0);
  endtask

  task automatic t_vector;
    mode_sel = 2'b01;
    load(63, 8'hc3, 1);
    send(2, 2, 3, 63, 0);
    chk(out_tag == 8'h5a && out_hint_en, "R7 vector idx 3", out_tag, 8'h5a);
    send(1, 1, 63, 3, 0);
    chk(out_tag == 8'hc3, "R7 vector idx 63", out_tag, 8'hc3);
  endtask

  task automatic t_context;
    mode_sel = 2'b10;
    send(1, 0, 3, 63, 0);
    chk(out_tag == 8'hc3, "R8 ctx idx 63", out_tag, 8'hc3);
    send(3, 2, 63, 3, 0);
    chk(out_tag == 8'h5a, "R8 ctx idx 3", out_tag, 8'h5a);
    mode_sel = 2'b11;
    send(1, 0, 3, 3, 0);
    chk(out_tag == 0 && out_hint_en, "R6 mode 3 no tag", out_tag, 0);
  endtask

  task automatic t_invalid;
    mode_sel = 2'b10;
    send(1, 1, 0, 20, 0);
    chk(out_tag == 0 && out_hint_en && out_hint == 2'b01, "R9 unprogrammed", out_tag, 0);
    load(3, 8'h77, 0);
    send(1, 1, 0, 3, 0);
    chk(out_tag == 0 && out_hint_en, "R9 invalidated", out_tag, 0);
  endtask

  task automatic t_hintwrite;
    sethint(1, 3);
    sethint(0, 2);
    mode_sel = 2'b00;
    send(1, 1, 0, 0, 0);
    chk(out_hint == 2'b11, "R5 header rewrite", out_hint, 3);
    send(1, 0, 0, 0, 0);
    chk(out_hint == 2'b10, "R5 desc rewrite", out_hint, 2);
    send(1, 2, 0, 0, 0);
    chk(out_hint == 2'b10, "R5 payload kept", out_hint, 2);
  endtask

  task automatic t_stall_mode;
    mode_sel = 2'b01;
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_kind = 2; in_class = 2; in_vec = 63; in_addr = 32'h300;
    @(negedge clk);
    chk(out_valid && !in_ready, "R2 stall blocks", in_ready, 0);
    in_kind = 1; in_addr = 32'h304; in_vec = 0; mode_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk(out_tag == 8'hc3 && out_addr == 32'h300, "R10 held tag", out_tag, 8'hc3);
    chk(out_kind == 2'b10, "R2 held kind", out_kind, 2);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid && out_addr == 32'h304 && out_tag == 0, "R10 new mode", out_tag, 0);
    @(negedge clk);
    chk(!out_valid, "R2 drained", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_other();
    t_vector();
    t_context();
    t_invalid();
    t_hintwrite();
    t_stall_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule